// File: doc/BRIEF.md
# Extended I/O Interrupt Router

This block gathers edge-signalled interrupt requests from 256 device vectors and hands them to the four cores of a single node. A rising edge on a vector input sets that vector's bit in a pending status array. Software clears pending bits by writing ones to them. Each vector has an enable bit. A route byte per vector names the target core as a one-hot mask and carries a node number. Each group of 32 vectors has an IP-map byte, and that byte chooses which of the eight interrupt lines of the target core the group drives.

Software reaches every register through a simple port with read and write strobes. The port moves either one 32-bit word or an aligned pair of words. A bounce array and a node-map array are only stored and read back. When the global enable input is low, every core line is held low.

Top module: `eio_vec_router`

## Requirements
- R1: A rising edge on `irq_in[n]` sets pending bit n whether or not vector n is enabled. Pending bits read back as 32-bit words at 0x1800 + 4*k, where word k holds vectors 32k..32k+31 with vector n at bit n%32. The same bits read as 64-bit pairs at 0x1800 + 8*w, with vector n at bit n%64 of pair n/64.
- R2: A write to a status word clears the pending bits written as one. Bits written as zero are left unchanged.
- R3: If a rising edge and a clearing write reach the same pending bit in the same cycle, the bit ends up set.
- R4: Enable words sit at 0x1600 + (v>>5)*4, with vector v at bit v&31. They reset to zero and read back what was written. A vector whose enable bit is clear drives no core line.
- R5: Route bytes sit at word 0x1c00 + (v & ~3), in byte lane v&3 (bits 8*(v&3)+7 down to 8*(v&3)). Bits 3:0 are a one-hot core mask and bits 7:4 are a node number. Only node 0 delivers. Route bytes reset to zero.
- R6: IP-map byte g (covering vectors 32g..32g+31) sits in word 0x14c0 + 4*(g>>2), lane g&3. When bit k of that byte is set, the group drives line k. Line k of core c is `core_ip[c*8+k]`.
- R7: Bounce words at 0x1680 + 4*j and node-map words at 0x14a0 + 4*j (j from 0 to 7) hold and read back any 32-bit value.
- R8: While `glb_en` is low, `core_ip` is all zero on the next cycle.
- R9: `core_ip` is registered. Core c line k goes high one cycle after the state first holds a vector that is pending, enabled, routed to node 0 with core bit c set, and in a group whose IP-map bit k is set. This is two clock edges after the input rises.
- R10: `reg_rdata` is loaded one cycle after `reg_rd`. A 32-bit read (`reg_wide`=0) returns the word at `reg_addr` in bits 31:0 and zero in bits 63:32. A wide read also returns the word at `reg_addr`+4 in bits 63:32. A wide write puts `reg_wdata[63:32]` into `reg_addr`+4. Unmapped addresses read as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| glb_en | input | 1 | Global delivery enable |
| irq_in | input | 256 | Edge-triggered vector requests |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_wide | input | 1 | 1: 64-bit access (two words), 0: 32-bit |
| reg_addr | input | 13 | Byte offset, word aligned |
| reg_wdata | input | 64 | Write data |
| reg_rdata | output | 64 | Read data, registered |
| core_ip | output | 32 | Per-core interrupt lines, core c line k at c*8+k |

## Verification
Two functions can hit the same pending bit in one cycle: a new rising edge on a vector, and a software write that clears that bit. The bench provokes this by raising the input on the same falling edge on which it drives a clearing write to the status word. It then reads the word back and expects the bit still set. The bench also checks the more common case, where a clearing write with only unrelated ones leaves an older pending bit alone and a later clear removes it.

// File: rtl/eio_vec_router.sv
module eio_vec_router #(
  parameter int NUM_VEC   = 256,
  parameter int NUM_CORES = 4,
  parameter int NUM_LINES = 8,
  parameter int AW        = 13
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           glb_en,
  input  logic [NUM_VEC-1:0]             irq_in,
  input  logic                           reg_wr,
  input  logic                           reg_rd,
  input  logic                           reg_wide,
  input  logic [AW-1:0]                  reg_addr,
  input  logic [63:0]                    reg_wdata,
  output logic [63:0]                    reg_rdata,
  output logic [NUM_CORES*NUM_LINES-1:0] core_ip
);
  localparam int GRP     = NUM_VEC / 32;
  localparam int IPW     = (GRP + 3) / 4;
  localparam int RTW     = NUM_VEC / 4;
  localparam int NM_BASE = 'h14a0;
  localparam int IP_BASE = 'h14c0;
  localparam int EN_BASE = 'h1600;
  localparam int BN_BASE = 'h1680;
  localparam int ST_BASE = 'h1800;
  localparam int RT_BASE = 'h1c00;

  logic [NUM_VEC-1:0] pend_q, en_q, bnc_q, irq_d, clr, rise;
  logic [31:0] nmap_q [GRP];
  logic [31:0] ipm_q  [IPW];
  logic [31:0] rt_q   [RTW];
  logic [AW-1:0] addr_hi;
  logic [NUM_CORES*NUM_LINES-1:0] ip_d;
  logic [GRP-1:0] hit [NUM_CORES];

  assign addr_hi = reg_addr + AW'(4);
  assign rise    = irq_in & ~irq_d;

  function automatic logic whit(input int a);
    return reg_wr && ((reg_addr[AW-1:2] == (AW-2)'(a >> 2)) ||
                      (reg_wide && addr_hi[AW-1:2] == (AW-2)'(a >> 2)));
  endfunction

  function automatic logic [31:0] wdat(input int a);
    return (reg_addr[AW-1:2] == (AW-2)'(a >> 2)) ? reg_wdata[31:0] : reg_wdata[63:32];
  endfunction

  function automatic logic [31:0] rword(input logic [AW-1:0] a);
    for (int j = 0; j < GRP; j++) begin
      if (a[AW-1:2] == (AW-2)'((NM_BASE + 4*j) >> 2)) return nmap_q[j];
      if (a[AW-1:2] == (AW-2)'((EN_BASE + 4*j) >> 2)) return en_q[32*j +: 32];
      if (a[AW-1:2] == (AW-2)'((BN_BASE + 4*j) >> 2)) return bnc_q[32*j +: 32];
      if (a[AW-1:2] == (AW-2)'((ST_BASE + 4*j) >> 2)) return pend_q[32*j +: 32];
    end
    for (int j = 0; j < IPW; j++)
      if (a[AW-1:2] == (AW-2)'((IP_BASE + 4*j) >> 2)) return ipm_q[j];
    for (int j = 0; j < RTW; j++)
      if (a[AW-1:2] == (AW-2)'((RT_BASE + 4*j) >> 2)) return rt_q[j];
    return 32'h0;
  endfunction

  always_comb begin
    for (int k = 0; k < GRP; k++)
      clr[32*k +: 32] = whit(ST_BASE + 4*k) ? wdat(ST_BASE + 4*k) : 32'h0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend_q <= '0;
      irq_d  <= '0;
    end else begin
      irq_d  <= irq_in;
      pend_q <= (pend_q & ~clr) | rise;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en_q  <= '0;
      bnc_q <= '0;
      for (int j = 0; j < GRP; j++) nmap_q[j] <= '0;
      for (int j = 0; j < IPW; j++) ipm_q[j]  <= '0;
      for (int j = 0; j < RTW; j++) rt_q[j]   <= '0;
    end else begin
      for (int j = 0; j < GRP; j++) begin
        if (whit(EN_BASE + 4*j)) en_q[32*j +: 32]  <= wdat(EN_BASE + 4*j);
        if (whit(BN_BASE + 4*j)) bnc_q[32*j +: 32] <= wdat(BN_BASE + 4*j);
        if (whit(NM_BASE + 4*j)) nmap_q[j]         <= wdat(NM_BASE + 4*j);
      end
      for (int j = 0; j < IPW; j++)
        if (whit(IP_BASE + 4*j)) ipm_q[j] <= wdat(IP_BASE + 4*j);
      for (int j = 0; j < RTW; j++)
        if (whit(RT_BASE + 4*j)) rt_q[j] <= wdat(RT_BASE + 4*j);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)      reg_rdata <= '0;
    else if (reg_rd) reg_rdata <= {reg_wide ? rword(addr_hi) : 32'h0, rword(reg_addr)};
  end

  always_comb begin
    for (int c = 0; c < NUM_CORES; c++) begin
      hit[c] = '0;
      for (int v = 0; v < NUM_VEC; v++)
        if (pend_q[v] && en_q[v] && rt_q[v/4][8*(v%4)+4 +: 4] == 4'h0 && rt_q[v/4][8*(v%4)+c])
          hit[c][v/32] = 1'b1;
    end
    for (int c = 0; c < NUM_CORES; c++)
      for (int k = 0; k < NUM_LINES; k++) begin
        ip_d[c*NUM_LINES+k] = 1'b0;
        for (int g = 0; g < GRP; g++)
          if (glb_en && hit[c][g] && ipm_q[g/4][8*(g%4)+k]) ip_d[c*NUM_LINES+k] = 1'b1;
      end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) core_ip <= '0;
    else        core_ip <= ip_d;
  end

  AST_EDGE_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_in[0] && !irq_d[0]) |=> pend_q[0]); // R3
  AST_CLEAR_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && !reg_wide && reg_addr == AW'(ST_BASE) && reg_wdata[0] && !(irq_in[0] && !irq_d[0])) |=> !pend_q[0]); // R2
  AST_OFF_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !glb_en |=> core_ip == '0); // R8
  AST_MASKED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (en_q == '0) |=> core_ip == '0); // R4
  AST_NARROW_READ: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rd && !reg_wide) |=> reg_rdata[63:32] == 32'h0); // R10
endmodule

// File: tb/eio_vec_router_tb.sv
module eio_vec_router_tb;
  logic clk = 0, rst_n = 0, glb_en = 0;
  logic [255:0] irq_in = '0;
  logic reg_wr = 0, reg_rd = 0, reg_wide = 0;
  logic [12:0] reg_addr = '0;
  logic [63:0] reg_wdata = '0;
  logic [63:0] reg_rdata;
  logic [31:0] core_ip;
  int checks = 0, errors = 0;
  logic [63:0] rv;

  always #10 clk = ~clk;

  eio_vec_router u_dut (.clk(clk), .rst_n(rst_n), .glb_en(glb_en), .irq_in(irq_in),
    .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_wide(reg_wide), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .core_ip(core_ip));

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [12:0] a, input logic [63:0] d, input logic wide);
    @(negedge clk); reg_wr = 1; reg_addr = a; reg_wdata = d; reg_wide = wide;
    @(negedge clk); reg_wr = 0; reg_wide = 0;
  endtask

  task automatic rd(input logic [12:0] a, input logic wide, output logic [63:0] d);
    @(negedge clk); reg_rd = 1; reg_addr = a; reg_wide = wide;
    @(negedge clk); reg_rd = 0; reg_wide = 0; d = reg_rdata;
  endtask

  task automatic pulse(input int v);
    @(negedge clk); irq_in[v] = 1;
    @(negedge clk); irq_in[v] = 0;
  endtask

  task automatic t_reset;
    check("R9 reset core_ip", 64'(core_ip), 64'h0);
    rd(13'h1808, 1, rv); check("R1 reset status", rv, 64'h0);
    rd(13'h1600, 0, rv); check("R4 reset enable", rv, 64'h0);
    rd(13'h1c44, 0, rv); check("R5 reset route", rv, 64'h0);
  endtask

  task automatic t_pending_masked;
    glb_en = 1;
    pulse(70);
    @(negedge clk); check("R4 disabled vector quiet", 64'(core_ip), 64'h0);
    rd(13'h1808, 1, rv); check("R1 wide status pair", rv, 64'h40);
    rd(13'h1808, 0, rv); check("R1 narrow status word", rv, 64'h40);
  endtask

  task automatic t_clear;
    wr(13'h1808, 64'h80, 0);
    rd(13'h1808, 0, rv); check("R2 zero bits keep pending", rv, 64'h40);
    wr(13'h1808, 64'h40, 0);
    rd(13'h1808, 0, rv); check("R2 one clears pending", rv, 64'h0);
  endtask

  task automatic t_deliver;
    wr(13'h1608, 64'h40, 0);
    rd(13'h1608, 0, rv); check("R4 enable readback", rv, 64'h40);
    wr(13'h1c44, 64'h0002_0000, 0);
    wr(13'h14c0, 64'h0008_0000, 0);
    pulse(70);
    @(negedge clk); check("R9 R5 R6 core1 line3", 64'(core_ip), 64'h800);
    glb_en = 0;
    @(negedge clk); check("R8 global off", 64'(core_ip), 64'h0);
    glb_en = 1;
    @(negedge clk); check("R8 global back on", 64'(core_ip), 64'h800);
    wr(13'h1c44, 64'h0012_0000, 0);
    @(negedge clk); check("R5 remote node quiet", 64'(core_ip), 64'h0);
    wr(13'h1c44, 64'h0002_0000, 0);
    @(negedge clk); check("R5 node0 restored", 64'(core_ip), 64'h800);
    wr(13'h1608, 64'h0, 0);
    @(negedge clk); check("R4 disable masks", 64'(core_ip), 64'h0);
    wr(13'h1808, 64'h40, 0);
  endtask

  task automatic t_second_route;
    wr(13'h1600, 64'h8, 0);
    wr(13'h1c00, 64'h0800_0000, 0);
    wr(13'h14c0, 64'h0008_0001, 0);
    pulse(3);
    @(negedge clk); check("R6 R9 core3 line0", 64'(core_ip), 64'h0100_0000);
    wr(13'h1800, 64'h8, 0);
    @(negedge clk); check("R2 clear drops line", 64'(core_ip), 64'h0);
  endtask

  task automatic t_collide;
    @(negedge clk);
    irq_in[70] = 1; reg_wr = 1; reg_addr = 13'h1808; reg_wdata = 64'h40; reg_wide = 0;
    @(negedge clk); reg_wr = 0; irq_in[70] = 0;
    rd(13'h1808, 0, rv); check("R3 edge beats clear", rv, 64'h40);
    wr(13'h1808, 64'h40, 0);
    rd(13'h1808, 0, rv); check("R3 later clear works", rv, 64'h0);
  endtask

  task automatic t_storage;
    wr(13'h1688, 64'hdead_beef_1234_5678, 1);
    rd(13'h1688, 0, rv); check("R7 bounce low", rv, 64'h1234_5678);
    rd(13'h168c, 0, rv); check("R7 bounce high", rv, 64'hdead_beef);
    wr(13'h14bc, 64'ha5a5_0f0f, 0);
    rd(13'h14bc, 0, rv); check("R7 node map", rv, 64'ha5a5_0f0f);
    rd(13'h14b8, 1, rv); check("R10 wide read pair", rv, 64'ha5a5_0f0f_0000_0000);
    rd(13'h0100, 1, rv); check("R10 unmapped zero", rv, 64'h0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_pending_masked();
    t_clear();
    t_deliver();
    t_second_route();
    t_collide();
    t_storage();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog actual=running expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule